// File: doc/BRIEF.md
# ESF Superframe Overhead Inserter

This block is the transmit-side framer for a 24-frame extended superframe on a DS1 line. It produces one line bit per clock. Each frame is one framing slot followed by 24 channels of eight bits. The block takes payload bits from a serial input. In the framing slot it substitutes one of three interleaved overhead streams: the frame alignment sequence, the CRC-6 check bits of the previous superframe, or a facility data-link bit. In the signalling frames it also overwrites the least significant bit of enabled channels with robbed-bit signalling.

The data-link bit is read from a serial input in the framing slot of every odd frame. A strobe marks that cycle, once every two frames. A yellow-alarm control replaces the link bits with a fixed alternating pattern. An active-low superframe sync input restarts the frame count at frame 1 from the next frame boundary. When it is held high, the counter runs freely.

A two-state machine sequences the slots. In `SLOT_FRAMING`, transition `t_open` always leads to `SLOT_PAYLOAD` after one slot. In `SLOT_PAYLOAD`, transition `t_next_bit` stays in that state while channel bits remain. Transition `t_frame_done` returns to `SLOT_FRAMING` after bit 8 of channel 24 and advances or realigns the frame count.

Top module: `esf_oh_inserter`

## Requirements
- R1: While `rst_n` is low, `line_bit`, `fbit_flag` and `frame_no` are 0. The first clock edge after release outputs the framing slot of frame 1.
- R2: Outputs lag inputs by one clock. Each frame is 193 output slots: one slot with `fbit_flag`=1, then 192 payload slots. `frame_no` counts 1 to 24 and wraps back to 1.
- R3: In frames 4, 8, 12, 16, 20 and 24, the framing bit is 0, 0, 1, 0, 1, 1 respectively.
- R4: In frames 2, 6, 10, 14, 18 and 22, the framing bit is CRC bit 5 down to bit 0 of the previous completed superframe. The CRC uses generator x^6+x+1 with initial value zero. It is shifted over every transmitted bit, with each framing bit counted as 1. It is all zeros until the first superframe after reset completes.
- R5: In odd frames, the framing bit is `fdl_in` as sampled in that framing slot. `fdl_tick` is high exactly in the framing slots of odd frames.
- R6: While `yellow_en` is high, the odd-frame framing bits form the repeating pattern of eight 1s followed by eight 0s. The pattern starts at the first link position after `yellow_en` rises.
- R7: Payload slots that are not robbed carry `pay_in` unchanged. Channel bits are sent first bit first, and the eighth bit of a channel is its least significant bit.
- R8: In frames 6, 12, 18 and 24, the eighth bit of each enabled channel c (0-based) carries `sig_abcd[4c+3]` (A), `sig_abcd[4c+2]` (B), `sig_abcd[4c+1]` (C) or `sig_abcd[4c]` (D) respectively.
- R9: Robbing is skipped for every channel when `rbs_off` is high, and for channel c when `chan_rbs_en[c]` is low. Skipped slots carry `pay_in`.
- R10: A low level on `sf_sync_n` makes the frame after the current one frame 1. When this cuts a superframe short, the CRC accumulation restarts from zero and the held CRC is kept.
- R11: With `sf_sync_n` held high, frames run 1 to 24 continuously.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sf_sync_n | input | 1 | Active-low superframe realign request |
| pay_in | input | 1 | Serial payload bit for the current slot |
| fdl_in | input | 1 | Serial facility data-link bit |
| yellow_en | input | 1 | Replace link bits by the yellow pattern |
| rbs_off | input | 1 | Disable robbed-bit signalling on all channels |
| chan_rbs_en | input | N_CH | Per-channel robbed-bit enable |
| sig_abcd | input | 4*N_CH | A/B/C/D signalling bits, four per channel |
| line_bit | output | 1 | Transmitted line bit |
| fbit_flag | output | 1 | High when `line_bit` is a framing bit |
| frame_no | output | 5 | Frame number (1..24) of the slot on `line_bit` |
| fdl_tick | output | 1 | Strobe: `fdl_in` is read in this cycle |

## Verification
Two situations are hard to reach from the ports. The first is a CRC bit that depends on a whole earlier superframe that was itself affected by robbing and by a realign. The second is a sync request arriving in the very last slot of a frame. The stimulus runs complete superframes of varied payload, link, enable and signalling patterns. It then applies sync pulses in mid-frame, in the last slot, and held across several frames. Every framing bit after those events is compared against a CRC recomputed in the bench from the stored transmitted stream.

// File: rtl/esf_pkg.sv
`timescale 1ns/1ps
package esf_pkg;
    localparam int SF_FRAMES = 24;
    localparam int FR_W      = $clog2(SF_FRAMES + 1);
    localparam int CRC_W     = 6;
    // alignment bit k (k = 0..5) for frames 4,8,...,24
    localparam logic [5:0] ALIGN_SEQ = 6'b110100;

    typedef enum logic [0:0] {
        SLOT_FRAMING = 1'b0,
        SLOT_PAYLOAD = 1'b1
    } slot_state_e;

    // one serial step of generator x^6 + x + 1
    function automatic logic [CRC_W-1:0] crc6_step(input logic [CRC_W-1:0] c, input logic b);
        logic fb;
        fb = c[CRC_W-1] ^ b;
        return {c[CRC_W-2:0], 1'b0} ^ {{(CRC_W-2){1'b0}}, fb, fb};
    endfunction
endpackage

// File: rtl/esf_slot_ctr.sv
`timescale 1ns/1ps
module esf_slot_ctr
    import esf_pkg::*;
#(
    parameter int N_CH = 24,
    parameter int W_CH = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sync_n,
    output slot_state_e             state,
    output logic [FR_W-1:0]         frame_idx,
    output logic [$clog2(N_CH)-1:0] ch_idx,
    output logic [$clog2(W_CH)-1:0] bit_idx,
    output logic                    sf_end,
    output logic                    restart
);
    localparam int CH_W = $clog2(N_CH);
    localparam int BT_W = $clog2(W_CH);

    logic sync_pend;
    logic frame_end;
    logic take_sync;
    logic last_frame;
    logic [FR_W-1:0] frame_nxt;

    assign frame_end  = (state == SLOT_PAYLOAD) && (ch_idx == CH_W'(N_CH - 1))
                        && (bit_idx == BT_W'(W_CH - 1));
    assign take_sync  = sync_pend | ~sync_n;
    assign last_frame = (frame_idx == FR_W'(SF_FRAMES - 1));
    assign frame_nxt  = (take_sync || last_frame) ? '0 : frame_idx + FR_W'(1);
    assign sf_end     = frame_end && last_frame;
    assign restart    = frame_end && take_sync && !last_frame;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= SLOT_FRAMING;
            frame_idx <= '0;
            ch_idx    <= '0;
            bit_idx   <= '0;
        end else begin
            unique case (state)
                SLOT_FRAMING: begin            // t_open
                    state   <= SLOT_PAYLOAD;
                    ch_idx  <= '0;
                    bit_idx <= '0;
                end
                SLOT_PAYLOAD: begin
                    if (bit_idx == BT_W'(W_CH - 1)) begin
                        bit_idx <= '0;
                        if (ch_idx == CH_W'(N_CH - 1)) begin   // t_frame_done
                            state     <= SLOT_FRAMING;
                            frame_idx <= frame_nxt;
                        end else begin
                            ch_idx <= ch_idx + CH_W'(1);
                        end
                    end else begin                  // t_next_bit
                        bit_idx <= bit_idx + BT_W'(1);
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)          sync_pend <= 1'b0;
        else if (frame_end)  sync_pend <= 1'b0;
        else if (!sync_n)    sync_pend <= 1'b1;
    end
endmodule

// File: rtl/esf_crc6.sv
`timescale 1ns/1ps
module esf_crc6
    import esf_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_in,
    input  logic             sf_end,
    input  logic             restart,
    output logic [CRC_W-1:0] crc_hold
);
    logic [CRC_W-1:0] acc;
    logic [CRC_W-1:0] acc_nxt;

    assign acc_nxt = crc6_step(acc, bit_in);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc      <= '0;
            crc_hold <= '0;
        end else if (sf_end) begin
            crc_hold <= acc_nxt;
            acc      <= '0;
        end else if (restart) begin
            acc      <= '0;
        end else begin
            acc      <= acc_nxt;
        end
    end
endmodule

// File: rtl/esf_fbit_mux.sv
`timescale 1ns/1ps
module esf_fbit_mux
    import esf_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fslot,
    input  logic [FR_W-1:0]  frame_idx,
    input  logic             fdl_in,
    input  logic             yellow_en,
    input  logic [CRC_W-1:0] crc_hold,
    output logic             fbit,
    output logic             fdl_tick
);
    logic [3:0] ycnt;
    logic [2:0] grp;

    assign grp      = frame_idx[4:2];
    assign fdl_tick = fslot && !frame_idx[0];   // frame numbers 1,3,5,...

    always_comb begin
        unique case (frame_idx[1:0])
            2'b00, 2'b10: fbit = yellow_en ? ~ycnt[3] : fdl_in;
            2'b01:        fbit = crc_hold[3'd5 - grp];
            2'b11:        fbit = ALIGN_SEQ[grp];
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !yellow_en) ycnt <= '0;
        else if (fdl_tick)        ycnt <= ycnt + 4'd1;
    end
endmodule

// File: rtl/esf_oh_inserter.sv
`timescale 1ns/1ps
module esf_oh_inserter
    import esf_pkg::*;
#(
    parameter int N_CH = 24,
    parameter int W_CH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sf_sync_n,
    input  logic              pay_in,
    input  logic              fdl_in,
    input  logic              yellow_en,
    input  logic              rbs_off,
    input  logic [N_CH-1:0]   chan_rbs_en,
    input  logic [4*N_CH-1:0] sig_abcd,
    output logic              line_bit,
    output logic              fbit_flag,
    output logic [4:0]        frame_no,
    output logic              fdl_tick
);
    localparam int CH_W = $clog2(N_CH);
    localparam int BT_W = $clog2(W_CH);

    slot_state_e      st;
    logic [FR_W-1:0]  fidx;
    logic [CH_W-1:0]  cidx;
    logic [BT_W-1:0]  bidx;
    logic             sfend, rstrt;
    logic [CRC_W-1:0] crc_hold;
    logic             fbit;
    logic             sig_frame;
    logic [1:0]       sig_sel;
    logic [CH_W+1:0]  sidx;
    logic             rob;
    logic             tx_bit;
    logic             crc_bit;

    esf_slot_ctr #(.N_CH(N_CH), .W_CH(W_CH)) u_ctr (
        .clk(clk), .rst_n(rst_n), .sync_n(sf_sync_n),
        .state(st), .frame_idx(fidx), .ch_idx(cidx), .bit_idx(bidx),
        .sf_end(sfend), .restart(rstrt)
    );

    esf_fbit_mux u_fmux (
        .clk(clk), .rst_n(rst_n), .fslot(st == SLOT_FRAMING), .frame_idx(fidx),
        .fdl_in(fdl_in), .yellow_en(yellow_en), .crc_hold(crc_hold),
        .fbit(fbit), .fdl_tick(fdl_tick)
    );

    esf_crc6 u_crc (
        .clk(clk), .rst_n(rst_n), .bit_in(crc_bit),
        .sf_end(sfend), .restart(rstrt), .crc_hold(crc_hold)
    );

    always_comb begin
        sig_frame = 1'b1;
        case (fidx)
            FR_W'(5):  sig_sel = 2'd0;
            FR_W'(11): sig_sel = 2'd1;
            FR_W'(17): sig_sel = 2'd2;
            FR_W'(23): sig_sel = 2'd3;
            default: begin
                sig_sel   = 2'd0;
                sig_frame = 1'b0;
            end
        endcase
    end

    assign sidx    = {cidx, ~sig_sel};
    assign rob     = (st == SLOT_PAYLOAD) && sig_frame && !rbs_off
                     && chan_rbs_en[cidx] && (bidx == BT_W'(W_CH - 1));
    assign tx_bit  = (st == SLOT_FRAMING) ? fbit : (rob ? sig_abcd[sidx] : pay_in);
    assign crc_bit = (st == SLOT_FRAMING) ? 1'b1 : tx_bit;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_bit  <= 1'b0;
            fbit_flag <= 1'b0;
            frame_no  <= '0;
        end else begin
            line_bit  <= tx_bit;
            fbit_flag <= (st == SLOT_FRAMING);
            frame_no  <= 5'(fidx) + 5'd1;
        end
    end
endmodule

// File: rtl/esf_oh_checker.sv
`timescale 1ns/1ps
module esf_oh_checker
    import esf_pkg::*;
#(
    parameter int N_CH = 24,
    parameter int W_CH = 8
) (
    input logic       clk,
    input logic       rst_n,
    input logic       sf_sync_n,
    input logic       line_bit,
    input logic       fbit_flag,
    input logic [4:0] frame_no,
    input logic       fdl_tick
);
    localparam int FRAME_LEN = N_CH * W_CH + 1;
    localparam int GAP_W     = $clog2(FRAME_LEN + 2);

    logic [GAP_W-1:0] gap;
    logic             seen;
    logic             pend_c, pend_old;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap <= '0; seen <= 1'b0; pend_c <= 1'b0; pend_old <= 1'b0;
        end else begin
            if (fbit_flag) begin
                gap      <= GAP_W'(1);
                seen     <= 1'b1;
                pend_c   <= !sf_sync_n;
                pend_old <= 1'b0;
            end else begin
                if (gap != '1) gap <= gap + GAP_W'(1);
                if (!sf_sync_n) pend_c <= 1'b1;
                pend_old <= pend_c;
            end
        end
    end

    a_r2_fbit_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (fbit_flag && seen) |-> (gap == GAP_W'(FRAME_LEN)));

    a_r2_frame_range: assert property (@(posedge clk) disable iff (!rst_n)
        fbit_flag |-> (frame_no >= 5'd1 && frame_no <= 5'd24));

    a_r5_tick_then_link: assert property (@(posedge clk) disable iff (!rst_n)
        fdl_tick |=> (fbit_flag && frame_no[0]));

    a_r3_align_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (fbit_flag && frame_no[1:0] == 2'b00) |-> (line_bit == ALIGN_SEQ[frame_no[4:2] - 3'd1]));

    a_r10_sync_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (fbit_flag && pend_old) |-> (frame_no == 5'd1));
endmodule

bind esf_oh_inserter esf_oh_checker #(.N_CH(N_CH), .W_CH(W_CH)) u_chk (
    .clk(clk), .rst_n(rst_n), .sf_sync_n(sf_sync_n), .line_bit(line_bit),
    .fbit_flag(fbit_flag), .frame_no(frame_no), .fdl_tick(fdl_tick)
);

// File: tb/esf_oh_inserter_test.sv
`timescale 1ns/1ps
module esf_oh_inserter_test;
    localparam int NCH = 24;
    localparam int SFB = 24 * 193;
    localparam logic [5:0] ALGN = 6'b110100;
    // stimulus vectors: [7] yellow [6] rbs_off [5:4] chan enable mode [3:2] payload mode [1:0] link mode
    localparam logic [7:0] VECS [0:5] = '{8'b0000_1111, 8'b0001_1110, 8'b0100_0111,
                                          8'b1000_1101, 8'b0010_0011, 8'b1011_1010};

    logic clk = 0, rst_n = 0, sf_sync_n = 1, pay_in = 0, fdl_in = 0, yellow_en = 0, rbs_off = 0;
    logic [NCH-1:0] chan_rbs_en = '1;
    logic [4*NCH-1:0] sig_abcd = '0;
    logic line_bit, fbit_flag, fdl_tick;
    logic [4:0] frame_no;

    int tests = 0, fails = 0;
    int mpos = 0, mframe = 0, ycnt = 0, nb = 0;
    bit mpend = 0;
    logic [5:0] crcm = '0;
    bit sfb [0:SFB-1];
    logic [15:0] lf = 16'hACE1;
    bit done = 0;

    always #4 clk = ~clk;

    esf_oh_inserter uut (
        .clk(clk), .rst_n(rst_n), .sf_sync_n(sf_sync_n), .pay_in(pay_in), .fdl_in(fdl_in),
        .yellow_en(yellow_en), .rbs_off(rbs_off), .chan_rbs_en(chan_rbs_en), .sig_abcd(sig_abcd),
        .line_bit(line_bit), .fbit_flag(fbit_flag), .frame_no(frame_no), .fdl_tick(fdl_tick)
    );

    function automatic logic [5:0] crc_of(input int n);
        logic [5:0] c = '0;
        for (int i = 0; i < n; i++) begin
            logic fb = c[5] ^ sfb[i];
            c = {c[4:0], 1'b0} ^ (fb ? 6'b000011 : 6'b000000);
        end
        return c;
    endfunction

    function automatic logic gen(input int mode);
        case (mode)
            0: return 1'b0;
            1: return 1'b1;
            2: return mpos[0];
            default: return lf[0];
        endcase
    endfunction

    task automatic model_reset();
        mpos = 0; mframe = 0; ycnt = 0; nb = 0; mpend = 0; crcm = '0;
    endtask

    task automatic slot(input logic p, input logic f, input logic s);
        logic e;
        string tag;
        bit tick_ok;
        if (!yellow_en) ycnt = 0;
        tick_ok = (fdl_tick === (mpos == 0 && mframe % 2 == 0));
        if (mpos == 0) begin
            if (mframe % 2 == 0) begin
                if (yellow_en) begin e = (ycnt % 16) < 8; ycnt++; tag = "R6"; end
                else begin e = f; tag = "R5"; end
            end else if (mframe % 4 == 1) begin
                e = crcm[5 - mframe / 4]; tag = "R4";
            end else begin
                e = ALGN[mframe / 4]; tag = "R3";
            end
        end else begin
            int ch = (mpos - 1) / 8;
            int b  = (mpos - 1) % 8;
            e = p; tag = "R7";
            if (mframe % 6 == 5 && b == 7) begin
                tag = "R8/R9";
                if (!rbs_off && chan_rbs_en[ch]) e = sig_abcd[ch * 4 + 3 - mframe / 6];
            end
        end
        pay_in = p; fdl_in = f; sf_sync_n = s;
        @(posedge clk);
        @(negedge clk);
        tests++;
        if (line_bit !== e || fbit_flag !== (mpos == 0) || frame_no !== 5'(mframe + 1) || !tick_ok) begin
            fails++;
            $display("FAIL %s,R2/R10 frame %0d slot %0d: line=%b fbit=%b frame_no=%0d tick_ok=%0d expected line=%b fbit=%0d frame_no=%0d",
                     tag, mframe + 1, mpos, line_bit, fbit_flag, frame_no, tick_ok, e, mpos == 0, mframe + 1);
        end
        sfb[nb] = (mpos == 0) ? 1'b1 : e;
        nb++;
        if (mpos == 192) begin
            bit take = mpend || !s;
            if (mframe == 23) begin crcm = crc_of(nb); nb = 0; end
            else if (take) nb = 0;
            mframe = (take || mframe == 23) ? 0 : mframe + 1;
            mpend = 0;
            mpos = 0;
        end else begin
            mpos++;
            if (!s) mpend = 1;
        end
    endtask

    task automatic run_n(input int n, input int pmode, input int fmode, input logic s);
        for (int i = 0; i < n; i++) begin
            slot(gen(pmode), gen(fmode), s);
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        end
    endtask

    task automatic check_reset(input string tag);
        tests++;
        if (line_bit !== 1'b0 || fbit_flag !== 1'b0 || frame_no !== 5'd0) begin
            fails++;
            $display("FAIL %s reset state: line=%b fbit=%b frame_no=%0d expected 0 0 0",
                     tag, line_bit, fbit_flag, frame_no);
        end
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            summary();
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check_reset("R1");
        rst_n = 1;
        model_reset();

        // table walk; R11: sync held high, free running superframes
        for (int v = 0; v < 6; v++) begin
            logic [7:0] cfg = VECS[v];
            yellow_en = cfg[7];
            rbs_off   = cfg[6];
            case (cfg[5:4])
                2'd0: chan_rbs_en = '1;
                2'd1: chan_rbs_en = 24'h555555;
                2'd2: chan_rbs_en = '0;
                default: chan_rbs_en = 24'h000FFF;
            endcase
            sig_abcd = {3{32'h9E3779B9 + 32'(v) * 32'h01234567}};
            run_n(2 * SFB, int'(cfg[3:2]), int'(cfg[1:0]), 1'b1);
        end

        // R10: sync pulse in mid-frame
        yellow_en = 0; rbs_off = 0; chan_rbs_en = '1;
        while (!(mframe == 6 && mpos == 50)) run_n(1, 3, 3, 1'b1);
        run_n(1, 3, 3, 1'b0);
        run_n(SFB + 2000, 3, 3, 1'b1);
        // R10: sync in the last slot of a frame
        while (mpos != 192) run_n(1, 3, 3, 1'b1);
        run_n(1, 3, 3, 1'b0);
        run_n(SFB, 3, 3, 1'b1);
        // R10: sync held low across several frames
        run_n(600, 3, 2, 1'b0);
        run_n(SFB + 300, 3, 2, 1'b1);
        // R6: yellow raised in the middle of a superframe
        yellow_en = 1;
        run_n(SFB, 3, 3, 1'b1);
        yellow_en = 0;

        // R1/R4: reset mid-run, CRC bits zero in the first superframe after
        @(negedge clk);
        rst_n = 0;
        @(posedge clk);
        @(negedge clk);
        check_reset("R1");
        rst_n = 1;
        model_reset();
        run_n(SFB + 500, 3, 3, 1'b1);

        done = 1;
        summary();
    end
endmodule